// File: doc/BRIEF.md
# Click-Free Audio Source Switch Sequencer

This block selects one of two signed stereo PCM streams and passes it to the output without audible clicks. Every frame, on a rising edge of the asynchronous frame clock, it takes one left and one right sample from the chosen source. An input gate may force the sample to zero. A mute stage then either passes the sample or outputs silence. The stage changes between silence and signal only when the signal crosses zero, and each channel does this on its own.

Software controls the block through a write strobe and three bits: output enable, source select and input enable. A mute or unmute request, and any change of the input gate, takes effect only at a frame. A single auto strobe runs the whole switch to the other source. It mutes and waits for both channels to go silent. It then counts a fixed number of frames, flips the source and unmutes on the next zero crossings of the new source. A timeout forces a pending mute or unmute through if the signal never crosses zero. A flag shows when the zeros from a closed input gate have had time to settle downstream.

Top module: `click_free_switch`

## Requirements
- R1: After the output enable is cleared, each channel keeps outputting the selected sample until a frame in which that channel crosses zero. From that frame on it outputs 0. A zero crossing means the current sample is 0, or its sign bit differs from the sign bit of the previous sample on that channel.
- R2: After the output enable is set, a muted channel stays at 0 until a frame in which it crosses zero while the input gate is open. From that frame on it outputs the sample. While the gate is closed, the unmute stays pending.
- R3: The input enable is sampled only at a frame edge. In every frame where the gate is closed, the sample of both channels is forced to 0.
- R4: `deep_muted` rises once SETTLE_FRAMES further frames have passed with the gate closed after the frame in which it closed. It drops in the first frame the gate is open.
- R5: While idle, a pulse on `auto_go` starts a switch. The block requests mute and waits until both channels are muted. It then waits WAIT_FRAMES more frames and flips `sel_now` in the last of them, sets `wait_done` and requests unmute. It returns to idle once both channels are unmuted. `wait_done` is cleared when the next switch starts.
- R6: If a mute, or an unmute with the gate open, stays pending for TIMEOUT_FRAMES frames, it is forced in the last of those frames, even without a zero crossing.
- R7: `out_valid` pulses for exactly one clock per rising edge of `lrclk`, three clock edges after the edge is sampled. The outputs and status change only together with it or after a control write.
- R8: While `busy` is high, writes to output enable and source select, and `auto_go` pulses, are ignored. Input enable writes are always accepted.
- R9: After reset, both channels are muted, the output is 0, source 0 is selected, the gate is open, and `busy`, `wait_done`, `deep_muted` and `out_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lrclk | input | 1 | Asynchronous frame clock; each rising edge starts a frame |
| s0_l | input | DW | Source 0 left sample, two's complement |
| s0_r | input | DW | Source 0 right sample |
| s1_l | input | DW | Source 1 left sample |
| s1_r | input | DW | Source 1 right sample |
| ctl_we | input | 1 | Control write strobe |
| ctl_out_en | input | 1 | Output enable bit (0 requests mute) |
| ctl_sel | input | 1 | Source select bit |
| ctl_in_en | input | 1 | Input enable bit (0 closes the input gate) |
| auto_go | input | 1 | Starts an automatic switch to the other source |
| out_l | output | DW | Left output sample |
| out_r | output | DW | Right output sample |
| out_valid | output | 1 | One-clock pulse per frame with new outputs |
| muted | output | 1 | Both channels muted |
| busy | output | 1 | Automatic switch in progress |
| wait_done | output | 1 | Switch wait count has finished |
| deep_muted | output | 1 | Gate-closed zeros have settled |
| sel_now | output | 1 | Currently selected source |

## Verification
The bench builds the block with WAIT_FRAMES = 8, SETTLE_FRAMES = 4 and TIMEOUT_FRAMES = 16 instead of 4096, 30 and 65536. With these values a full automatic switch, the settling of a closed gate and a forced mute on a constant input each finish within a few dozen frames. The triangle streams hit exact zeros on one source and only sign changes on the other, so both ways of detecting a crossing are exercised. The two channels are out of phase, so they mute and unmute in different frames.

// File: rtl/click_free_switch.sv
module click_free_switch #(
  parameter int DW             = 16,
  parameter int WAIT_FRAMES    = 4096,
  parameter int SETTLE_FRAMES  = 30,
  parameter int TIMEOUT_FRAMES = 65536
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lrclk,
  input  logic [DW-1:0] s0_l,
  input  logic [DW-1:0] s0_r,
  input  logic [DW-1:0] s1_l,
  input  logic [DW-1:0] s1_r,
  input  logic          ctl_we,
  input  logic          ctl_out_en,
  input  logic          ctl_sel,
  input  logic          ctl_in_en,
  input  logic          auto_go,
  output logic [DW-1:0] out_l,
  output logic [DW-1:0] out_r,
  output logic          out_valid,
  output logic          muted,
  output logic          busy,
  output logic          wait_done,
  output logic          deep_muted,
  output logic          sel_now
);
  localparam int WCW = $clog2(WAIT_FRAMES + 1);
  localparam int TCW = $clog2(TIMEOUT_FRAMES + 1);
  localparam int SCW = $clog2(SETTLE_FRAMES + 1);

  typedef enum logic [1:0] {S_IDLE, S_MUTE, S_WAIT, S_UNMUTE} st_t;

  st_t           st;
  logic [2:0]    sy;
  logic          in_en_q, gate_q, want_mute, mute_l, mute_r, sel_q;
  logic [DW-1:0] prev_l, prev_r;
  logic [WCW-1:0] wcnt;
  logic [TCW-1:0] tcnt;
  logic [SCW-1:0] dcnt;

  wire rise = sy[1] & ~sy[2];
  wire gate_nx = in_en_q;
  wire [DW-1:0] smp_l = gate_nx ? (sel_q ? s1_l : s0_l) : '0;
  wire [DW-1:0] smp_r = gate_nx ? (sel_q ? s1_r : s0_r) : '0;
  wire zc_l = (smp_l[DW-1] != prev_l[DW-1]) || (smp_l == '0);
  wire zc_r = (smp_r[DW-1] != prev_r[DW-1]) || (smp_r == '0);
  wire pend_l = want_mute ? ~mute_l : mute_l;
  wire pend_r = want_mute ? ~mute_r : mute_r;
  wire act = (pend_l | pend_r) & (want_mute | gate_nx);
  wire frc = act && (tcnt == TCW'(TIMEOUT_FRAMES - 1));
  wire mute_l_nx = want_mute ? (mute_l | zc_l | frc) : (mute_l & ~(gate_nx & (zc_l | frc)));
  wire mute_r_nx = want_mute ? (mute_r | zc_r | frc) : (mute_r & ~(gate_nx & (zc_r | frc)));

  assign muted      = mute_l & mute_r;
  assign busy       = (st != S_IDLE);
  assign sel_now    = sel_q;
  assign deep_muted = (dcnt == SCW'(SETTLE_FRAMES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy <= '0; out_valid <= 1'b0; out_l <= '0; out_r <= '0;
      in_en_q <= 1'b1; gate_q <= 1'b1; want_mute <= 1'b1; sel_q <= 1'b0;
      mute_l <= 1'b1; mute_r <= 1'b1; prev_l <= '0; prev_r <= '0;
      wcnt <= '0; tcnt <= '0; dcnt <= '0; st <= S_IDLE; wait_done <= 1'b0;
    end else begin
      sy <= {sy[1:0], lrclk};
      out_valid <= rise;
      if (ctl_we) begin
        in_en_q <= ctl_in_en;
        if (!busy) begin
          want_mute <= ~ctl_out_en;
          sel_q     <= ctl_sel;
        end
      end
      if (auto_go && st == S_IDLE) begin
        want_mute <= 1'b1;
        wait_done <= 1'b0;
        st        <= S_MUTE;
      end
      if (rise) begin
        gate_q <= gate_nx;
        mute_l <= mute_l_nx;
        mute_r <= mute_r_nx;
        prev_l <= smp_l;
        prev_r <= smp_r;
        out_l  <= mute_l_nx ? '0 : smp_l;
        out_r  <= mute_r_nx ? '0 : smp_r;
        tcnt   <= (act && !frc) ? tcnt + 1'b1 : '0;
        if (gate_nx) dcnt <= '0;
        else if (!gate_q && dcnt != SCW'(SETTLE_FRAMES)) dcnt <= dcnt + 1'b1;
        case (st)
          S_MUTE: if (mute_l_nx && mute_r_nx) begin
            wcnt <= '0;
            st   <= S_WAIT;
          end
          S_WAIT: if (wcnt == WCW'(WAIT_FRAMES - 1)) begin
            sel_q     <= ~sel_q;
            want_mute <= 1'b0;
            wait_done <= 1'b1;
            st        <= S_UNMUTE;
          end else wcnt <= wcnt + 1'b1;
          S_UNMUTE: if (!mute_l_nx && !mute_r_nx) st <= S_IDLE;
          default: ;
        endcase
      end
    end
  end

  p_silent_when_muted_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && muted) |-> (out_l == '0 && out_r == '0));
  p_gate_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !gate_q) |-> (out_l == '0 && out_r == '0));
  p_deep_needs_closed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    deep_muted |-> !gate_q);
  p_switch_while_muted_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$stable(sel_q)) |-> (muted && wait_done));
  p_valid_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
endmodule

// File: tb/test_click_free_switch.sv
module test_click_free_switch;
  localparam int DW = 16, WAITF = 8, SETF = 4, TMO = 16;

  logic clk = 1'b0, rst_n = 1'b0, lrclk = 1'b0;
  logic [DW-1:0] s0_l = '0, s0_r = '0, s1_l = '0, s1_r = '0;
  logic ctl_we = 1'b0, ctl_out_en = 1'b0, ctl_sel = 1'b0, ctl_in_en = 1'b1, auto_go = 1'b0;
  logic [DW-1:0] out_l, out_r;
  logic out_valid, muted, busy, wait_done, deep_muted, sel_now;

  always #5 clk = ~clk;

  click_free_switch #(.DW(DW), .WAIT_FRAMES(WAITF), .SETTLE_FRAMES(SETF), .TIMEOUT_FRAMES(TMO))
    i_click_free_switch (.clk, .rst_n, .lrclk, .s0_l, .s0_r, .s1_l, .s1_r, .ctl_we, .ctl_out_en,
      .ctl_sel, .ctl_in_en, .auto_go, .out_l, .out_r, .out_valid, .muted, .busy, .wait_done,
      .deep_muted, .sel_now);

  int n_chk = 0, n_fail = 0, k = 0, dc_mode = 0;
  bit done = 0;

  // behavioural reference state
  bit m_in_en = 1, m_gate = 1, m_wm = 1, m_sel = 0, m_ml = 1, m_mr = 1, m_wd = 0;
  int m_st = 0, m_wc = 0, m_tc = 0, m_dc = 0;
  logic signed [DW-1:0] m_pl = 0, m_pr = 0, e_l = 0, e_r = 0;

  function automatic logic signed [DW-1:0] tri_w(input int i);
    int p = i % 16;
    return (p < 8) ? DW'(-400 + 100 * p) : DW'(400 - 100 * (p - 8));
  endfunction

  function automatic bit zc(input logic signed [DW-1:0] c, input logic signed [DW-1:0] p);
    return ((c < 0) != (p < 0)) || (c == 0);
  endfunction

  task automatic check(input string tag, input bit ok, input string act_s, input string exp_s);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%s expected=%s", tag, act_s, exp_s);
    end
  endtask

  task automatic compare(input string tag, input bit vexp);
    string a, e;
    a = $sformatf("l=%0d r=%0d v=%0b m=%0b b=%0b wd=%0b dm=%0b s=%0b", $signed(out_l), $signed(out_r),
                  out_valid, muted, busy, wait_done, deep_muted, sel_now);
    e = $sformatf("l=%0d r=%0d v=%0b m=%0b b=%0b wd=%0b dm=%0b s=%0b", e_l, e_r, vexp,
                  m_ml & m_mr, m_st != 0, m_wd, m_dc == SETF, m_sel);
    check(tag, a == e, a, e);
  endtask

  task automatic model_frame(input logic signed [DW-1:0] a0l, a0r, a1l, a1r);
    bit g, zl, zr, pl, pr, act, frc;
    logic signed [DW-1:0] sl, sr;
    g  = m_in_en;
    sl = g ? (m_sel ? a1l : a0l) : 0;
    sr = g ? (m_sel ? a1r : a0r) : 0;
    zl = zc(sl, m_pl); zr = zc(sr, m_pr);
    pl = m_wm ? !m_ml : m_ml; pr = m_wm ? !m_mr : m_mr;
    act = (pl || pr) && (m_wm || g);
    frc = act && (m_tc == TMO - 1);
    if (m_wm) begin
      if (zl || frc) m_ml = 1;
      if (zr || frc) m_mr = 1;
    end else if (g) begin
      if (zl || frc) m_ml = 0;
      if (zr || frc) m_mr = 0;
    end
    m_tc = act ? (frc ? 0 : m_tc + 1) : 0;
    m_pl = sl; m_pr = sr;
    if (g) m_dc = 0; else if (!m_gate && m_dc < SETF) m_dc++;
    m_gate = g;
    e_l = m_ml ? 0 : sl; e_r = m_mr ? 0 : sr;
    case (m_st)
      1: if (m_ml && m_mr) begin m_wc = 0; m_st = 2; end
      2: if (m_wc == WAITF - 1) begin m_sel = !m_sel; m_wm = 0; m_wd = 1; m_st = 3; end
         else m_wc++;
      3: if (!m_ml && !m_mr) m_st = 0;
      default: ;
    endcase
  endtask

  task automatic frame(input string tag);
    logic signed [DW-1:0] a0l, a0r, a1l, a1r;
    @(negedge clk);
    if (dc_mode != 0) begin a0l = 1000; a0r = 1000; a1l = 1000; a1r = 1000; end
    else begin a0l = tri_w(k); a0r = tri_w(k + 2); a1l = tri_w(k + 5) + 7; a1r = tri_w(k + 9) + 7; end
    k++;
    s0_l = a0l; s0_r = a0r; s1_l = a1l; s1_r = a1r;
    lrclk = 1'b1;
    model_frame(a0l, a0r, a1l, a1r);
    repeat (3) @(negedge clk);
    compare({tag, " R7 frame"}, 1'b1);
    @(negedge clk);
    check("R7 pulse width", out_valid == 1'b0, $sformatf("%0b", out_valid), "0");
    lrclk = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input bit oe, input bit sl, input bit ie);
    @(negedge clk);
    ctl_we = 1'b1; ctl_out_en = oe; ctl_sel = sl; ctl_in_en = ie;
    @(negedge clk);
    ctl_we = 1'b0;
    m_in_en = ie;
    if (m_st == 0) begin m_wm = !oe; m_sel = sl; end
  endtask

  task automatic go();
    @(negedge clk);
    auto_go = 1'b1;
    @(negedge clk);
    auto_go = 1'b0;
    if (m_st == 0) begin m_wm = 1; m_wd = 0; m_st = 1; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R9 reset", 1'b0);
    for (int i = 0; i < 3; i++) frame("R9 idle muted");
    // manual unmute on source 0 (exact zeros)
    wr(1, 0, 1);
    for (int i = 0; i < 12; i++) frame("R2 unmute src0");
    // manual mute: per-channel zero crossing
    wr(0, 0, 1);
    for (int i = 0; i < 12; i++) frame("R1 mute src0");
    // manual select of source 1 and unmute (sign changes only)
    wr(0, 1, 1);
    wr(1, 1, 1);
    for (int i = 0; i < 14; i++) frame("R2 unmute src1");
    // automatic switch back to source 0, with writes during busy
    go();
    frame("R5 auto start");
    wr(0, 1, 1);
    check("R8 sel write ignored", sel_now == 1'b1, $sformatf("%0b", sel_now), "1");
    go();
    for (int i = 0; i < 30; i++) begin
      frame("R5 auto switch");
      if (i == 4) begin
        wr(1, 0, 1);
        check("R8 write ignored while busy", busy == 1'b1, $sformatf("%0b", busy), "1");
      end
    end
    check("R5 switched to src0", sel_now == 1'b0 && wait_done && !busy,
          $sformatf("s=%0b wd=%0b b=%0b", sel_now, wait_done, busy), "s=0 wd=1 b=0");
    // gate closed: zeros and settling flag, unmute pending while closed
    wr(0, 0, 0);
    for (int i = 0; i < 8; i++) frame("R3 R4 gate closed");
    wr(1, 0, 0);
    for (int i = 0; i < 20; i++) frame("R2 pending unmute");
    check("R2 stays muted with gate closed", muted == 1'b1, $sformatf("%0b", muted), "1");
    wr(1, 0, 1);
    for (int i = 0; i < 12; i++) frame("R3 R4 gate open");
    // constant input: forced mute after timeout
    dc_mode = 1;
    for (int i = 0; i < 3; i++) frame("R6 dc settle");
    wr(0, 0, 1);
    for (int i = 0; i < 10; i++) frame("R6 dc mute pending");
    check("R6 not yet forced", muted == 1'b0, $sformatf("%0b", muted), "0");
    for (int i = 0; i < 10; i++) frame("R6 dc mute forced");
    check("R6 forced mute", muted == 1'b1, $sformatf("%0b", muted), "1");
    wr(1, 0, 1);
    for (int i = 0; i < 20; i++) frame("R6 dc unmute forced");
    check("R6 forced unmute", muted == 1'b0, $sformatf("%0b", muted), "0");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule